// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block times the SCL line of an I2C master from the system clock. Software sets an 8-bit clock control register that holds a speed-mode bit and a 7-bit divider. While the peripheral is enabled and the master sequencer asks to run, the block drives SCL low and releases it in turn. It also emits a one-cycle tick at each SCL falling edge and at each rising edge. The byte shifter uses the falling tick to change SDA and the rising tick to sample it.

Let B be the divider plus two. In standard mode SCL is low for B system clocks and high for B system clocks. In fast mode the low phase is stretched to 2·B, so the period is 3·B. A new register value is applied only when the next SCL period begins. Clearing the peripheral enable releases SCL but leaves the register as it was. The rates assume unloaded lines, so no rise-time delay is modelled.

Top module: `i2c_scl_gen`

## Requirements
- R1: After reset the control register reads 00h, SCL is released (`scl_drive_low` = 0) and neither tick is asserted.
- R2: A write (`cfg_wr` = 1) stores `cfg_wdata` at the clock edge. From the next cycle `cfg_rdata` returns all 8 bits. Bit 7 is the fast-mode flag and bits 6:0 are the divider B−2. Without a write the register holds its value.
- R3: Clearing `periph_en` does not alter the register. Writes made while it is low are still accepted.
- R4: In standard mode (bit 7 = 0), `scl_drive_low` is 1 for B cycles and then 0 for B cycles, repeatedly.
- R5: In fast mode (bit 7 = 1), `scl_drive_low` is 1 for 2·B cycles and then 0 for B cycles, repeatedly.
- R6: A register write made during a period does not change that period's low or high length. The new value applies from the next falling edge.
- R7: While `periph_en` or `run_req` is 0, SCL is released from the next cycle and no ticks occur. The first cycle in which both are 1 causes SCL to be driven low from the following cycle.
- R8: `tick_fall` is 1 for exactly the first cycle of each low phase. `tick_rise` is 1 for exactly the first cycle of each high phase. The two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 8 | Write data: bit 7 fast flag, bits 6:0 divider |
| cfg_rdata | output | 8 | Current control register value |
| periph_en | input | 1 | Peripheral enable |
| run_req | input | 1 | Run request from the master sequencer |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release it |
| tick_fall | output | 1 | One-cycle pulse at each SCL falling edge |
| tick_rise | output | 1 | One-cycle pulse at each SCL rising edge |

## Verification
Every output comes from a register, so each result is due one clock edge after the stimulus that causes it. A write is visible on `cfg_rdata` one edge later. A start request drives SCL low one edge later, and each phase boundary appears exactly B or 2·B edges after the previous boundary. The bench model advances at the same edge as the design and uses the register value from before a write made in that cycle. The bench changes inputs just after a rising edge and compares every output at the falling edge, so each comparison sees the result of exactly one edge.

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [DIV_W:0]   cfg_wdata,
  output logic [DIV_W:0]   cfg_rdata,
  input  logic             periph_en,
  input  logic             run_req,
  output logic             scl_drive_low,
  output logic             tick_fall,
  output logic             tick_rise
);
  localparam int CNT_W = DIV_W + 3;

  logic [DIV_W:0]   ctrl_q;
  logic [DIV_W-1:0] div_lat_q;
  logic [CNT_W-1:0] cnt_q;
  logic             low_q, tf_q, tr_q;

  wire              active   = periph_en & run_req;
  wire [CNT_W-1:0]  base_new = CNT_W'(ctrl_q[DIV_W-1:0]) + CNT_W'(2);
  wire [CNT_W-1:0]  low_new  = ctrl_q[DIV_W] ? (base_new << 1) : base_new;
  wire [CNT_W-1:0]  high_len = CNT_W'(div_lat_q) + CNT_W'(2);

  always_ff @(posedge clk) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (cfg_wr) ctrl_q <= cfg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      low_q     <= 1'b0;
      cnt_q     <= '0;
      tf_q      <= 1'b0;
      tr_q      <= 1'b0;
      if (!rst_n) div_lat_q <= '0;
    end else begin
      tf_q <= 1'b0;
      tr_q <= 1'b0;
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end else if (low_q) begin
        low_q <= 1'b0;
        cnt_q <= high_len - CNT_W'(1);
        tr_q  <= 1'b1;
      end else begin
        low_q     <= 1'b1;
        div_lat_q <= ctrl_q[DIV_W-1:0];
        cnt_q     <= low_new - CNT_W'(1);
        tf_q      <= 1'b1;
      end
    end
  end

  assign cfg_rdata     = ctrl_q;
  assign scl_drive_low = low_q;
  assign tick_fall     = tf_q;
  assign tick_rise     = tr_q;
endmodule

// File: rtl/i2c_scl_gen_chk.sv
module i2c_scl_gen_chk #(
  parameter int DIV_W = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_wr,
  input logic [DIV_W:0] cfg_wdata,
  input logic [DIV_W:0] cfg_rdata,
  input logic           periph_en,
  input logic           run_req,
  input logic           scl_drive_low,
  input logic           tick_fall,
  input logic           tick_rise
);
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_rdata == $past(cfg_wdata));
  a_r3_reg_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_rdata));
  a_r7_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !(periph_en && run_req) |=> !scl_drive_low && !tick_fall && !tick_rise);
  a_r8_fall_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> tick_fall);
  a_r8_rise_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |-> !scl_drive_low && $past(scl_drive_low));
  a_r8_fall_only_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fall |-> scl_drive_low && !$past(scl_drive_low));
  a_r8_ticks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_fall && tick_rise));
endmodule

bind i2c_scl_gen i2c_scl_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .periph_en(periph_en), .run_req(run_req),
  .scl_drive_low(scl_drive_low), .tick_fall(tick_fall), .tick_rise(tick_rise)
);

// File: tb/sim_i2c_scl_gen.sv
module sim_i2c_scl_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0, periph_en = 1'b0, run_req = 1'b0;
  logic [7:0] cfg_wdata = '0, cfg_rdata;
  logic scl_drive_low, tick_fall, tick_rise;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";

  int m_ctrl = 0, m_pos = -1, m_lo = 0, m_hi = 0;
  bit e_low = 0, e_tf = 0, e_tr = 0, model_on = 0;

  always #2.5 clk = ~clk;

  i2c_scl_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .periph_en(periph_en), .run_req(run_req),
    .scl_drive_low(scl_drive_low), .tick_fall(tick_fall), .tick_rise(tick_rise)
  );

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_ctrl = 0; m_pos = -1;
    end else begin
      if (!(periph_en && run_req)) m_pos = -1;
      else if (m_pos < 0 || m_pos == m_lo + m_hi - 1) begin
        m_hi  = (m_ctrl % 128) + 2;
        m_lo  = (m_ctrl >= 128) ? 2 * m_hi : m_hi;
        m_pos = 0;
      end else m_pos++;
      if (cfg_wr) m_ctrl = int'(cfg_wdata);
    end
    e_low = (m_pos >= 0) && (m_pos < m_lo);
    e_tf  = (m_pos == 0);
    e_tr  = (m_pos >= 0) && (m_pos == m_lo);
  end

  always @(negedge clk) if (model_on) begin
    check(tag, int'(scl_drive_low), int'(e_low), "scl_drive_low");
    check(tag, int'(tick_fall), int'(e_tf), "tick_fall");
    check(tag, int'(tick_rise), int'(e_tr), "tick_rise");
    check(tag, int'(cfg_rdata), m_ctrl, "cfg_rdata");
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [7:0] v);
    cfg_wr = 1'b1; cfg_wdata = v; step(1); cfg_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    step(3); rst_n = 1'b1; step(1);
    @(negedge clk);
    check("R1", int'(cfg_rdata), 0, "reset cfg_rdata");
    check("R1", int'(scl_drive_low), 0, "reset scl");
    check("R1", int'(tick_fall) + int'(tick_rise), 0, "reset ticks");
    model_on = 1; step(1);

    tag = "R2"; wr(8'hA5); @(negedge clk);
    check("R2", int'(cfg_rdata), 8'hA5, "readback");
    step(1); wr(8'h00); step(2);

    tag = "R4"; periph_en = 1; run_req = 1; step(20);
    wr(8'h05); step(60);
    tag = "R5"; wr(8'h83); step(70);
    wr(8'h80); step(30);
    tag = "R6"; wr(8'h0A); step(3); wr(8'h82); step(80);
    tag = "R3"; periph_en = 0; step(3); wr(8'h07); step(2);
    @(negedge clk);
    check("R3", int'(cfg_rdata), 8'h07, "kept over disable");
    check("R3", int'(scl_drive_low), 0, "released when disabled");
    step(1); periph_en = 1; step(50);
    tag = "R7"; run_req = 0; step(10); run_req = 1; step(1);
    @(negedge clk);
    check("R7", int'(scl_drive_low), 1, "restart drives low");
    check("R8", int'(tick_fall), 1, "fall tick on restart");
    step(40);
    tag = "R8"; wr(8'h81); step(50);
    finish_run();
  end

  initial begin
    wait (cycles > 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule